// File: doc/BRIEF.md
# DMA Read Abort Fatal Error Handler

This block sits beside the DMA engines of a USB host controller and deals with a memory read that the system bus rejects. The bus master reports each rejected read as one strobe, with a flag that tells a target abort from a master abort. The block treats every such event as fatal. It latches the error in the operational status register and in a configuration-space style device status register. It tells the schedule DMA engines to stop. When software has enabled them, it raises an interrupt and a system error pulse.

The engines get a short drain window. After the abort, at most one more USB transaction may finish. When the USB side reports that transaction done, or when a bounded wait passes with no completion, the engines count as halted, and a read-only halted flag reports this. The halt request stays up until software writes the run control register with its run bit at zero. Every error flag is sticky and is cleared by writing a one to it. Software reaches all state through a small select/write/read register port, and the read data is combinational on the select.

Top module: `hc_dma_abort_guard`

## Requirements
- R1: After reset, every register reads zero and `dma_halt`, `irq` and `serr` are low.
- R2: A cycle with `abort_valid` high sets the host system error flag, bit 4 of the operational status register (select 1), from the next cycle on. The abort type does not matter.
- R3: An abort with `abort_is_target` at 0 (master abort) sets bit 13 of the device status register (select 4). An abort with `abort_is_target` at 1 (target abort) sets bit 12. The other bit keeps its value.
- R4: If the system error enable, bit 8 of the command register (select 3), is 1 when the abort is sampled, `serr` pulses high for exactly the next cycle and bit 14 of the device status register is set. If the enable is 0, neither happens.
- R5: `irq` is high exactly while the host system error flag and its enable are both 1. The enable is bit 4 of the interrupt enable register (select 2), so `irq` falls when software clears the flag.
- R6: `dma_halt` rises in the cycle after an abort. During the drain window the halted flag, bit 12 of select 1, stays 0.
- R7: The first `xfer_done` seen during the drain window sets the halted flag in the next cycle. Further `xfer_done` strobes change nothing.
- R8: If no `xfer_done` arrives, the halted flag sets exactly `DRAIN_LIMIT` cycles after the abort cycle.
- R9: Each sticky flag (select 1 bit 4; select 4 bits 12, 13, 14) clears on a write of 1 to that bit. Writing 0 leaves it unchanged. An abort in the same cycle as a clear leaves the flag set.
- R10: A write to select 0 with bit 0 at 0 drops `dma_halt` and the halted flag in the next cycle. An abort in the same cycle wins, and the drain starts anyway.
- R11: An abort that arrives while draining or halted sets the status flags again. It neither restarts nor extends the drain window.
- R12: Bit 0 of select 0 (run) and the two enable bits are plain read/write bits. Unused selects and bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_sel | input | 3 | Register select for both read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| abort_valid | input | 1 | One-cycle strobe: a DMA memory read was aborted |
| abort_is_target | input | 1 | Abort type: 1 target abort, 0 master abort |
| xfer_done | input | 1 | One-cycle strobe: a USB transaction finished |
| dma_halt | output | 1 | Stop request to the schedule DMA engines |
| irq | output | 1 | Interrupt request, level |
| serr | output | 1 | System error pulse |

## Verification
The in-line assertions check these rules on every cycle: an abort always sets the error flag and the flag of its type, and an abort with the enable off never gives a system error pulse. They also check that an abort always leaves the halt request up, that a completion in the drain window always ends it, and that the drain counter stays inside its bound. Only the bench scenarios can show the timing of the drain window. These cover the exact timeout cycle, a second abort that does not restart it, and later completions being ignored. They also cover the write-one-to-clear rules and their collisions with a same-cycle abort, the release by the run bit and its loss to a same-cycle abort, and the read-back of every register. The behavioural model in the bench compares all of these on every clock.

// File: rtl/hcabt_pkg.sv
package hcabt_pkg;

   typedef enum logic [2:0] {
      SEL_RUNCTL  = 3'd0,
      SEL_OPSTAT  = 3'd1,
      SEL_OPIEN   = 3'd2,
      SEL_CFGCMD  = 3'd3,
      SEL_CFGSTAT = 3'd4
   } reg_sel_e;

   localparam int BIT_RUN     = 0;
   localparam int BIT_HSE     = 4;
   localparam int BIT_HALTED  = 12;
   localparam int BIT_SERR_EN = 8;
   localparam int BIT_RTA     = 12;
   localparam int BIT_RMA     = 13;
   localparam int BIT_SSE     = 14;
   localparam int MIN_DATA_W  = 15;

   typedef enum logic [1:0] {
      HS_IDLE   = 2'd0,
      HS_DRAIN  = 2'd1,
      HS_HALTED = 2'd2
   } halt_st_e;

endpackage

// File: rtl/hcabt_halt_fsm.sv
module hcabt_halt_fsm
   import hcabt_pkg::*;
#(
   parameter int DRAIN_LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort_valid,
   input  logic xfer_done,
   input  logic release_req,
   output logic halt_o,
   output logic halted_o
);

   localparam int CNT_W = $clog2(DRAIN_LIMIT + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_LIMIT - 1);

   initial begin
      assert (DRAIN_LIMIT >= 1) else $error("DRAIN_LIMIT must be at least 1");
   end

   halt_st_e         st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (release_req && !abort_valid) begin
         st_d  = HS_IDLE;
         cnt_d = '0;
      end else begin
         unique case (st_q)
            HS_IDLE: begin
               if (abort_valid) begin
                  st_d  = HS_DRAIN;
                  cnt_d = '0;
               end
            end
            HS_DRAIN: begin
               if (xfer_done || cnt_q == CNT_LAST) begin
                  st_d = HS_HALTED;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            HS_HALTED: st_d = HS_HALTED;
            default:   st_d = HS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= HS_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign halt_o   = (st_q != HS_IDLE);
   assign halted_o = (st_q == HS_HALTED);

   // R6
   abort_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_valid |=> halt_o);

   // R7
   done_ends_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_DRAIN && xfer_done && !release_req) |=> halted_o);

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);

endmodule

// File: rtl/hcabt_status_regs.sv
module hcabt_status_regs
   import hcabt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              abort_valid,
   input  logic              abort_is_target,
   input  logic              halted_i,
   output logic              release_o,
   output logic              hse_flag_o,
   output logic              hse_en_o,
   output logic              serr_o
);

   initial begin
      assert (DATA_W >= MIN_DATA_W) else $error("DATA_W too narrow for status fields");
   end

   logic run_q, hse_en_q, serr_en_q;
   logic hse_q, rta_q, rma_q, sse_q, serr_q;
   logic wr_run, wr_opstat, wr_opien, wr_cfgcmd, wr_cfgstat;

   assign wr_run     = reg_wr && (reg_sel == SEL_RUNCTL);
   assign wr_opstat  = reg_wr && (reg_sel == SEL_OPSTAT);
   assign wr_opien   = reg_wr && (reg_sel == SEL_OPIEN);
   assign wr_cfgcmd  = reg_wr && (reg_sel == SEL_CFGCMD);
   assign wr_cfgstat = reg_wr && (reg_sel == SEL_CFGSTAT);
   assign release_o  = wr_run && !reg_wdata[BIT_RUN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         hse_en_q  <= 1'b0;
         serr_en_q <= 1'b0;
      end else begin
         if (wr_run)    run_q     <= reg_wdata[BIT_RUN];
         if (wr_opien)  hse_en_q  <= reg_wdata[BIT_HSE];
         if (wr_cfgcmd) serr_en_q <= reg_wdata[BIT_SERR_EN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hse_q  <= 1'b0;
         rta_q  <= 1'b0;
         rma_q  <= 1'b0;
         sse_q  <= 1'b0;
         serr_q <= 1'b0;
      end else begin
         hse_q  <= abort_valid
                   | (hse_q & ~(wr_opstat & reg_wdata[BIT_HSE]));
         rta_q  <= (abort_valid & abort_is_target)
                   | (rta_q & ~(wr_cfgstat & reg_wdata[BIT_RTA]));
         rma_q  <= (abort_valid & ~abort_is_target)
                   | (rma_q & ~(wr_cfgstat & reg_wdata[BIT_RMA]));
         sse_q  <= (abort_valid & serr_en_q)
                   | (sse_q & ~(wr_cfgstat & reg_wdata[BIT_SSE]));
         serr_q <= abort_valid & serr_en_q;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel)
         SEL_RUNCTL:  reg_rdata[BIT_RUN] = run_q;
         SEL_OPSTAT: begin
            reg_rdata[BIT_HSE]    = hse_q;
            reg_rdata[BIT_HALTED] = halted_i;
         end
         SEL_OPIEN:   reg_rdata[BIT_HSE]     = hse_en_q;
         SEL_CFGCMD:  reg_rdata[BIT_SERR_EN] = serr_en_q;
         SEL_CFGSTAT: begin
            reg_rdata[BIT_RTA] = rta_q;
            reg_rdata[BIT_RMA] = rma_q;
            reg_rdata[BIT_SSE] = sse_q;
         end
         default:     reg_rdata = '0;
      endcase
   end

   assign hse_flag_o = hse_q;
   assign hse_en_o   = hse_en_q;
   assign serr_o     = serr_q;

   // R2
   abort_sets_hse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_valid |=> hse_flag_o);

   // R3
   target_sets_rta_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_valid && abort_is_target) |=> rta_q);

   // R3
   master_sets_rma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_valid && !abort_is_target) |=> rma_q);

   // R4
   serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_valid && !serr_en_q) |=> !serr_o);

   // R9
   hse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hse_q && !wr_opstat) |=> hse_q);

endmodule

// File: rtl/hc_dma_abort_guard.sv
module hc_dma_abort_guard
   import hcabt_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int DRAIN_LIMIT   = 64,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              abort_valid,
   input  logic              abort_is_target,
   input  logic              xfer_done,
   output logic              dma_halt,
   output logic              irq,
   output logic              serr
);

   logic release_req, halted, hse_flag, hse_en;

   hcabt_status_regs #(.DATA_W(DATA_W)) u_regs (
      .clk             (clk),
      .rst_n           (rst_n),
      .reg_sel         (reg_sel),
      .reg_wr          (reg_wr),
      .reg_wdata       (reg_wdata),
      .reg_rdata       (reg_rdata),
      .abort_valid     (abort_valid),
      .abort_is_target (abort_is_target),
      .halted_i        (halted),
      .release_o       (release_req),
      .hse_flag_o      (hse_flag),
      .hse_en_o        (hse_en),
      .serr_o          (serr)
   );

   hcabt_halt_fsm #(.DRAIN_LIMIT(DRAIN_LIMIT)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .abort_valid (abort_valid),
      .xfer_done   (xfer_done),
      .release_req (release_req),
      .halt_o      (dma_halt),
      .halted_o    (halted)
   );

   generate
      if (IRQ_REGISTERED) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= hse_flag & hse_en;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = hse_flag & hse_en;
      end
   endgenerate

   // R10
   halted_implies_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> dma_halt);

endmodule

// File: tb/hc_dma_abort_guard_test.sv
`timescale 1ns/1ps
module hc_dma_abort_guard_test;

   localparam int DW  = 16;
   localparam int LIM = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    reg_sel = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          abort_valid = 1'b0, abort_is_target = 1'b0, xfer_done = 1'b0;
   logic          dma_halt, irq, serr;

   int vectors = 0;
   int errors  = 0;

   // reference model state
   bit m_run, m_hen, m_sen, m_hse, m_rta, m_rma, m_sse, m_serr;
   int m_st  = 0;   // 0 idle, 1 drain, 2 halted
   int m_cnt = 0;
   int rot   = 0;

   always #2.5 clk = ~clk;

   hc_dma_abort_guard #(.DATA_W(DW), .DRAIN_LIMIT(LIM)) uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .abort_valid(abort_valid),
      .abort_is_target(abort_is_target), .xfer_done(xfer_done),
      .dma_halt(dma_halt), .irq(irq), .serr(serr));

   function automatic logic [DW-1:0] model_rd(input int sel);
      logic [DW-1:0] r = '0;
      case (sel)
         0: r[0] = m_run;
         1: begin r[4] = m_hse; r[12] = (m_st == 2); end
         2: r[4] = m_hen;
         3: r[8] = m_sen;
         4: begin r[12] = m_rta; r[13] = m_rma; r[14] = m_sse; end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [DW-1:0] e = model_rd(int'(reg_sel));
      string rq;
      case (reg_sel)
         3'd0: rq = "R12/R10 run ctl";
         3'd1: rq = "R2/R6/R7/R8 op status";
         3'd2: rq = "R12 irq enable";
         3'd3: rq = "R4 cmd";
         3'd4: rq = "R3/R4/R9 dev status";
         default: rq = "R12 unused select";
      endcase
      chk(reg_rdata === e, rq, int'(reg_rdata), int'(e));
      chk(dma_halt === (m_st != 0), "R6 dma_halt", int'(dma_halt), int'(m_st != 0));
      chk(irq === (m_hse & m_hen), "R5 irq", int'(irq), int'(m_hse & m_hen));
      chk(serr === m_serr, "R4 serr", int'(serr), int'(m_serr));
   endtask

   task automatic model_edge(input bit av, input bit at, input bit dn,
                             input bit we, input int sel, input logic [DW-1:0] wd);
      bit rel = we && sel == 0 && !wd[0];
      bit n_serr = av && m_sen;
      int n_st = m_st, n_cnt = m_cnt;
      if (rel && !av) begin n_st = 0; n_cnt = 0; end
      else if (m_st == 0 && av) begin n_st = 1; n_cnt = 0; end
      else if (m_st == 1) begin
         if (dn || m_cnt == LIM - 1) n_st = 2;
         else n_cnt = m_cnt + 1;
      end
      if (we && sel == 1 && wd[4])  m_hse = 0;
      if (we && sel == 4 && wd[12]) m_rta = 0;
      if (we && sel == 4 && wd[13]) m_rma = 0;
      if (we && sel == 4 && wd[14]) m_sse = 0;
      if (av) begin
         m_hse = 1;
         if (at) m_rta = 1; else m_rma = 1;
         if (m_sen) m_sse = 1;
      end
      if (we && sel == 0) m_run = wd[0];
      if (we && sel == 2) m_hen = wd[4];
      if (we && sel == 3) m_sen = wd[8];
      m_serr = n_serr;
      m_st   = n_st;
      m_cnt  = n_cnt;
   endtask

   // one clock: drive at negedge, compare, then advance model at posedge
   task automatic step(input bit av, input bit at, input bit dn,
                       input bit we, input int sel, input logic [DW-1:0] wd);
      @(negedge clk);
      abort_valid = av; abort_is_target = at; xfer_done = dn;
      reg_wr = we; reg_sel = 3'(sel); reg_wdata = wd;
      #1;
      compare();
      @(posedge clk);
      model_edge(av, at, dn, we, sel, wd);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         step(0, 0, 0, 0, rot % 6, '0);
         rot++;
      end
   endtask

   task automatic wr(input int sel, input logic [DW-1:0] wd);
      step(0, 0, 0, 1, sel, wd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired (all R) actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: reset state on every select
      idle(6);
      // R12: control bits read back, unused bits stay zero
      wr(0, 16'hFFFF); idle(6);
      wr(2, 16'h0010); wr(3, 16'h0100); idle(6);
      // R2 R3 R4 R5 R6: master abort with all enables on
      step(1, 0, 0, 0, 1, '0);
      idle(3);
      // R7: first completion halts, later ones ignored
      step(0, 0, 1, 0, 1, '0);
      step(0, 0, 1, 0, 1, '0);
      idle(6);
      // R9: writing zeros leaves flags, ones clear them
      wr(1, 16'h0000); wr(4, 16'h0000); idle(6);
      wr(1, 16'h0010); idle(2);
      wr(4, 16'h7000); idle(6);
      // R10: release via run bit 0
      wr(0, 16'h0000); idle(6);
      // R8: target abort, enables off, no completion -> timeout
      wr(2, 16'h0000); wr(3, 16'h0000);
      step(1, 1, 0, 0, 4, '0);
      idle(LIM + 4);
      wr(0, 16'h0000); idle(2);
      // R11: second abort during drain does not restart the window
      wr(3, 16'h0100); wr(2, 16'h0010);
      step(1, 0, 0, 0, 1, '0);
      idle(3);
      step(1, 1, 0, 0, 4, '0);
      idle(LIM + 2);
      step(1, 0, 0, 0, 1, '0);   // R11 abort while halted
      idle(4);
      // R9: clear collides with an abort, flag stays set
      step(1, 0, 0, 1, 1, 16'h0010);
      step(1, 1, 0, 1, 4, 16'h7000);
      idle(6);
      // R10: release collides with abort in halted state then from idle
      step(1, 0, 0, 1, 0, 16'h0000);
      idle(3);
      wr(0, 16'h0000);
      step(1, 0, 0, 1, 0, 16'h0000);   // abort wins: drain starts
      idle(3);
      step(0, 0, 1, 0, 1, '0);
      idle(4);
      wr(1, 16'h0010); wr(4, 16'h7000); wr(0, 16'h0000);
      idle(6);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule